// File: doc/BRIEF.md
# Block-Read Configuration Register Target (I2C)

This block is an I2C target that fronts a small bank of configuration registers. It watches SCL and SDA, which must already be synchronized to a system clock far faster than SCL. It pulls SDA low through an open-drain enable. The block recognizes START, repeated START and STOP. It answers one 7-bit device address, in both the write and the read direction, and keeps an internal register pointer that the host positions with an offset byte.

Writes work as a block. The host sends the write address, then the offset, then a count byte that the target accepts and discards. After that come data bytes, which land in successive registers until a STOP arrives.

A read begins with a write phase that carries only the offset. A repeated START with the read address follows. The target then returns one byte that holds the number of registers from the pointer to the end of the bank. After that it streams register contents upward from the pointer, until the host answers a byte with NACK.

Top module: `i2c_blk_target`

## Requirements
- R1: The target acknowledges only the address bytes {DEV_ADDR,0} (default D2h, write) and {DEV_ADDR,1} (default D3h, read). Any other address byte is not acknowledged, and SDA stays released for the rest of that transfer, until the next START.
- R2: The first byte after the write address sets the register pointer. A value of NUM_REGS or more is clamped to NUM_REGS-1.
- R3: After the read address is acknowledged, the first byte sent is the count NUM_REGS minus the pointer.
- R4: After the count, each byte the host acknowledges is followed by the register at the pointer, after which the pointer increments. Bytes go out most significant bit first.
- R5: The pointer saturates at NUM_REGS-1. Reading past the end repeats the last register, and writing past the end overwrites the last register.
- R6: In a block write, the byte after the offset is acknowledged and discarded. Each later byte is acknowledged and stored at the pointer, after which the pointer advances. No register changes without such a byte.
- R7: After a NACK from the host, the target releases SDA and drives nothing until the next START.
- R8: A START or STOP in the middle of a byte abandons that byte without storing it. A START re-arms address reception at once.
- R9: After reset, register i holds 5Ah XOR ((19*i) mod 256), and SDA is released.
- R10: The target changes its SDA drive only while SCL is low. It never pulls SDA while the host is sending data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |

## Verification
The bench builds the block with NUM_REGS = 6 and the default address 69h. This keeps the bank small enough that every begin offset from 0 to 7 can be read to the end. That sweep includes two offsets past the last register, which exercise the clamp. With only six registers, pointer saturation is reached within a few bytes, on both the read side and the write side. Aborts by START and by STOP, foreign addresses and early NACKs are each driven at offsets chosen so that the register they might corrupt is read back afterwards.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_TXNEXT
  } tgt_state_e;

  typedef enum logic [2:0] {
    PH_ADDR, PH_OFS, PH_CNT, PH_DATA, PH_READ
  } tgt_phase_e;

  // Power-on contents of register idx: 5Ah xor (19*idx) mod 256
  function automatic logic [7:0] reg_default(input int idx);
    logic [7:0] v;
    v = 8'(idx);
    return 8'h5A ^ ((v << 4) + (v << 1) + v);
  endfunction

  // Begin offset clamped into the bank
  function automatic int clamp_offset(input logic [7:0] m, input int n);
    return (int'(m) >= n) ? n - 1 : int'(m);
  endfunction

  // Registers remaining from ptr to the end of the bank
  function automatic logic [7:0] span_count(input int ptr, input int n);
    return 8'(n - ptr);
  endfunction

  // Pointer advance, saturating at the last register
  function automatic int sat_next(input int ptr, input int n);
    return (ptr >= n - 1) ? n - 1 : ptr + 1;
  endfunction

endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  assign start_evt = scl_in & scl_q & sda_q & ~sda_in;
  assign stop_evt  = scl_in & scl_q & ~sda_q & sda_in;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_blk_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [PW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [NUM_REGS-1:0][7:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= reg_default(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem)); // R6

endmodule

// File: rtl/i2c_blk_target.sv
module i2c_blk_target
  import i2c_blk_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int         PW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};

  tgt_state_e    state;
  tgt_phase_e    phase;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh;
  logic [PW-1:0] ptr;

  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] rx_byte, rdata, cnt_byte;
  logic byte_done, bank_we;

  i2c_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign rx_byte   = {sh[6:0], sda_in};
  assign byte_done = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7);
  assign bank_we   = byte_done && (phase == PH_DATA);
  assign cnt_byte  = span_count(int'(ptr), NUM_REGS);

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .waddr(ptr),
    .wdata(rx_byte), .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= 3'd0;
      sh      <= 8'h00;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_RX;
      phase   <= PH_ADDR;
      bit_cnt <= 3'd0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          sh      <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            state <= ST_ACK;
            unique case (phase)
              PH_ADDR: begin
                if (rx_byte == WR_ADDR)      phase <= PH_OFS;
                else if (rx_byte == RD_ADDR) phase <= PH_READ;
                else                         state <= ST_IDLE;
              end
              PH_OFS: begin
                ptr   <= PW'(clamp_offset(rx_byte, NUM_REGS));
                phase <= PH_CNT;
              end
              PH_CNT:  phase <= PH_DATA;
              default: ptr <= PW'(sat_next(int'(ptr), NUM_REGS));
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!sda_oe) begin
            sda_oe <= 1'b1;
          end else begin
            bit_cnt <= 3'd0;
            if (phase == PH_READ) begin
              state  <= ST_TX;
              sh     <= cnt_byte;
              sda_oe <= ~cnt_byte[7];
            end else begin
              state  <= ST_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            state   <= ST_TXACK;
            sda_oe  <= 1'b0;
            bit_cnt <= 3'd0;
          end else begin
            sh      <= {sh[6:0], 1'b0};
            sda_oe  <= ~sh[6];
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        ST_TXACK: if (scl_rise) state <= sda_in ? ST_IDLE : ST_TXNEXT;
        ST_TXNEXT: if (scl_fall) begin
          sh     <= rdata;
          sda_oe <= ~rdata[7];
          ptr    <= PW'(sat_next(int'(ptr), NUM_REGS));
          state  <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_RX && phase == PH_ADDR && bit_cnt == 3'd0)); // R8

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe)); // R8

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R7

  AST_PTR_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) <= NUM_REGS - 1); // R5

endmodule

// File: tb/i2c_blk_target_tb.sv
module i2c_blk_target_tb;
  localparam int NREG = 6;
  localparam int QTR  = 8;
  localparam logic [7:0] AW = 8'hD2;
  localparam logic [7:0] AR = 8'hD3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl = 1'b1;
  logic h_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;
  assign sda_bus = h_sda & ~sda_oe;

  i2c_blk_target #(.NUM_REGS(NREG), .DEV_ADDR(7'h69)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(h_scl), .sda_in(sda_bus), .sda_oe(sda_oe)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    h_sda = 1'b1; wait_q(); h_scl = 1'b1; wait_q();
    h_sda = 1'b0; wait_q(); h_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    h_sda = 1'b0; wait_q(); h_scl = 1'b1; wait_q(); h_sda = 1'b1; wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      h_sda = b[i]; wait_q(); h_scl = 1'b1; wait_q();
      check(sda_bus == b[i], "R10 host bit disturbed", sda_bus, b[i]);
      wait_q(); h_scl = 1'b0; wait_q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    h_sda = 1'b1; wait_q(); h_scl = 1'b1; wait_q();
    acked = ~sda_bus;
    wait_q(); h_scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    h_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(); h_scl = 1'b1; wait_q(); b[i] = sda_bus; wait_q(); h_scl = 1'b0; wait_q();
    end
    h_sda = ~give_ack; wait_q(); h_scl = 1'b1; wait_q(); wait_q();
    h_scl = 1'b0; wait_q(); h_sda = 1'b1;
  endtask

  // Offset write, repeated START, read count then nrd bytes
  task automatic read_check(input int m, input int nrd, input string tag);
    logic a;
    logic [7:0] b;
    int p;
    p = (m >= NREG) ? NREG - 1 : m;
    bus_start();
    send_byte(AW, a);      check(a, "R1 write address ack", a, 1);
    send_byte(8'(m), a);   check(a, "R2 offset ack", a, 1);
    bus_start();
    send_byte(AR, a);      check(a, "R1 read address ack", a, 1);
    recv_byte(b, 1'b1);
    check(b == 8'(NREG - p), {tag, " R3 count"}, b, NREG - p);
    for (int k = 0; k < nrd; k++) begin
      recv_byte(b, k < nrd - 1);
      check(b == model[p], {tag, " R4 data"}, b, model[p]);
      if (p < NREG - 1) p++;
    end
    bus_stop();
  endtask

  task automatic write_block(input int m, input logic [7:0] d0, input int nd);
    logic a;
    int p;
    p = (m >= NREG) ? NREG - 1 : m;
    bus_start();
    send_byte(AW, a);     check(a, "R1 write address ack", a, 1);
    send_byte(8'(m), a);  check(a, "R2 offset ack", a, 1);
    send_byte(8'hFF, a);  check(a, "R6 count byte ack", a, 1);
    for (int k = 0; k < nd; k++) begin
      send_byte(d0 + 8'(k * 37), a);
      check(a, "R6 data ack", a, 1);
      model[p] = d0 + 8'(k * 37);
      if (p < NREG - 1) p++;
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1..watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) model[i] = 8'((i * 19) % 256) ^ 8'h5A;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R9 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R9 sda released after reset", sda_oe, 0);

    // R2 R3 R4 R9: every begin offset, including past the end
    for (int m = 0; m < NREG + 2; m++) begin
      int len;
      len = (m >= NREG) ? 1 : NREG - m;
      read_check(m, len, "R9 sweep");
    end

    // R5: read beyond the end repeats the last register
    read_check(NREG - 2, 5, "R5 read saturate");

    // R1: foreign addresses are ignored until the next START
    bus_start();
    send_byte(8'hD0, a);  check(!a, "R1 foreign address not acked", a, 0);
    send_byte(8'h03, a);  check(!a, "R1 ignored byte not acked", a, 0);
    bus_start();
    send_byte(8'hD4, a);  check(!a, "R1 foreign address not acked", a, 0);
    bus_stop();
    read_check(0, NREG, "R1 bank untouched");

    // R6: block write, count byte discarded
    write_block(1, 8'h11, 3);
    read_check(0, NREG, "R6 readback");

    // R5: write past the end overwrites the last register
    write_block(NREG - 2, 8'hC3, 4);
    read_check(NREG - 3, 3, "R5 write saturate");

    // R7: after NACK nothing is driven until START
    bus_start();
    send_byte(AW, a); send_byte(8'h00, a);
    bus_start();
    send_byte(AR, a);
    recv_byte(b, 1'b1);
    recv_byte(b, 1'b0);
    check(b == model[0], "R7 byte before nack", b, model[0]);
    recv_byte(b, 1'b0);
    check(b == 8'hFF, "R7 released after nack", b, 8'hFF);
    bus_stop();

    // R8: START mid-byte drops the partial byte
    bus_start();
    send_byte(AW, a); send_byte(8'h02, a); send_byte(8'h00, a);
    send_bits(8'h00, 4);
    bus_start();
    send_byte(AW, a);
    check(a, "R8 restart accepted after abort", a, 1);
    bus_stop();
    read_check(2, 1, "R8 start abort");

    // R8: STOP mid-byte drops the partial byte
    bus_start();
    send_byte(AW, a); send_byte(8'h03, a); send_byte(8'h00, a);
    send_bits(8'h00, 5);
    bus_stop();
    read_check(3, 1, "R8 stop abort");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule